// File: doc/BRIEF.md
# Multi-Channel Wake-Up Interrupt Router

This block watches 64 input lines coming from internal peripherals and from pins. Each line is first brought into the block's clock domain through a two-flip-flop synchronizer. The block then watches it for a rising or falling transition, chosen per channel. A detected transition sets a sticky pending bit for that channel. Software clears the bit by writing a 1 to it.

The pending bits feed two outputs:

- **Interrupt lines.** Each channel carries a 3-bit selector that sends it to one of eight shared interrupt lines. A line is high while any channel that is pending, interrupt-enabled and mapped to it exists.
- **Wake-up request.** A separate wake-up request is high while any pending channel with its wake enable set exists. The power-mode logic outside the block uses it to return the device to active mode.

The register port is a simple word-addressed write/read port with a registered read path. It gives access to the interrupt enables, wake enables, edge polarity, pending bits and route selectors.

Top module: `wkr_top`

## Requirements
- R1: An input transition is synchronized through two flip-flops. If an input changes before clock edge E1, the pending bit is set at edge E3, and the interrupt and wake outputs change at edge E4. Before E4 they are unchanged.
- R2: Polarity bit 0 selects rising-edge detection and 1 selects falling-edge detection. A transition in the other direction leaves the pending bit clear.
- R3: A pending bit stays set until a write of 1 to that bit in the pending region. Writing 0 leaves it unchanged.
- R4: If a transition is detected on the same edge as a clear write to that channel, the pending bit ends set.
- R5: The route selector of channel c is bits [4j+2:4j] of route word 32+c/8, with j = c mod 8. Interrupt line k is high one cycle after some channel routed to k is pending and interrupt-enabled.
- R6: With its interrupt enable at 0, a channel still sets its pending bit but drives no interrupt line.
- R7: The wake output is high one cycle after any channel is pending with its wake enable set, independent of the interrupt enable. It stays high until those bits are cleared.
- R8: After reset, all configuration and pending bits are 0, all interrupt lines and the wake output are low, and read data is 0.
- R9: Word addresses are:
  - 0–1: interrupt enables
  - 8–9: wake enables
  - 16–17: polarity
  - 24–25: pending
  - 32–39: route selectors

  Bit b of word w (w = 0 or 1) in the first four regions is channel 32w+b. Read data appears one cycle after the address. Unmapped addresses read 0.
- R10: When several channels share a line, the line stays high until the last of them is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_i | input | 64 | Asynchronous wake/interrupt source lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 8 | Interrupt request lines |
| wake_o | output | 1 | Wake-up request |

## Verification
The checker enforces several properties on every cycle:

- A pending bit never drops without a write to the pending region.
- A bit never rises without a detected edge.
- A detected edge always survives a simultaneous clear.
- The wake output and interrupt lines only rise when enabled pending bits existed the cycle before.

Several behaviours are shown only by the bench's scenarios:

- The exact latency of the synchronizer path.
- Polarity selection.
- The nibble layout of the route words.
- Line sharing between channels.
- The set-wins-over-clear collision on a chosen cycle.

// File: rtl/wkr_pkg.sv
package wkr_pkg;
  localparam int DATA_W  = 32;
  localparam int FIELD_W = 4;

  typedef enum logic [2:0] {
    RGN_IEN   = 3'd0,
    RGN_WEN   = 3'd1,
    RGN_POL   = 3'd2,
    RGN_PEND  = 3'd3,
    RGN_ROUTE = 3'd4
  } region_e;
endpackage

// File: rtl/wkr_sync_edge.sv
module wkr_sync_edge #(
  parameter int N_CH        = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] raw_i,
  input  logic [N_CH-1:0] pol_i,
  output logic [N_CH-1:0] hit_o
);
  logic [N_CH-1:0] stg [SYNC_STAGES];
  logic [N_CH-1:0] prev_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else if (s == 0) stg[s] <= raw_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stg[SYNC_STAGES-1];
  end

  // a change in the selected direction: value differs from the previous
  // sample and the new value is the one the polarity asks for
  for (genvar c = 0; c < N_CH; c++) begin : g_hit
    assign hit_o[c] = (stg[SYNC_STAGES-1][c] ^ prev_q[c]) &
                      (stg[SYNC_STAGES-1][c] ^ pol_i[c]);
  end
endmodule

// File: rtl/wkr_regs.sv
module wkr_regs
  import wkr_pkg::*;
#(
  parameter int N_CH   = 64,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [N_CH-1:0]       hit_i,
  output logic [N_CH-1:0]       ien_o,
  output logic [N_CH-1:0]       wen_o,
  output logic [N_CH-1:0]       pol_o,
  output logic [N_CH-1:0]       pend_o,
  output logic [N_CH*SEL_W-1:0] route_o,
  output logic [DATA_W-1:0]     rdata_o
);
  localparam int IDX_W = ADDR_W - 3;
  localparam int NWB   = N_CH / DATA_W;
  localparam int CPR   = DATA_W / FIELD_W;
  localparam int NRW   = N_CH / CPR;

  logic [2:0]        rgn;
  logic [IDX_W-1:0]  idx;
  logic [N_CH-1:0]   clr;
  logic [DATA_W-1:0] rd_n;

  assign rgn = addr_i[ADDR_W-1:IDX_W];
  assign idx = addr_i[IDX_W-1:0];

  always_comb begin
    clr = '0;
    if (wr_i && rgn == RGN_PEND)
      for (int w = 0; w < NWB; w++)
        if (idx == IDX_W'(w)) clr[w*DATA_W +: DATA_W] = wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_o   <= '0;
      wen_o   <= '0;
      pol_o   <= '0;
      pend_o  <= '0;
      route_o <= '0;
    end else begin
      if (wr_i) begin
        for (int w = 0; w < NWB; w++) begin
          if (idx == IDX_W'(w)) begin
            if (rgn == RGN_IEN) ien_o[w*DATA_W +: DATA_W] <= wdata_i;
            if (rgn == RGN_WEN) wen_o[w*DATA_W +: DATA_W] <= wdata_i;
            if (rgn == RGN_POL) pol_o[w*DATA_W +: DATA_W] <= wdata_i;
          end
        end
        if (rgn == RGN_ROUTE)
          for (int r = 0; r < NRW; r++)
            if (idx == IDX_W'(r))
              for (int j = 0; j < CPR; j++)
                route_o[(r*CPR+j)*SEL_W +: SEL_W] <= wdata_i[j*FIELD_W +: SEL_W];
      end
      // new edges win over a clear on the same cycle
      pend_o <= (pend_o & ~clr) | hit_i;
    end
  end

  always_comb begin
    rd_n = '0;
    case (rgn)
      RGN_IEN:  for (int w = 0; w < NWB; w++) if (idx == IDX_W'(w)) rd_n = ien_o[w*DATA_W +: DATA_W];
      RGN_WEN:  for (int w = 0; w < NWB; w++) if (idx == IDX_W'(w)) rd_n = wen_o[w*DATA_W +: DATA_W];
      RGN_POL:  for (int w = 0; w < NWB; w++) if (idx == IDX_W'(w)) rd_n = pol_o[w*DATA_W +: DATA_W];
      RGN_PEND: for (int w = 0; w < NWB; w++) if (idx == IDX_W'(w)) rd_n = pend_o[w*DATA_W +: DATA_W];
      RGN_ROUTE:
        for (int r = 0; r < NRW; r++)
          if (idx == IDX_W'(r))
            for (int j = 0; j < CPR; j++)
              rd_n[j*FIELD_W +: SEL_W] = route_o[(r*CPR+j)*SEL_W +: SEL_W];
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_n;
  end
endmodule

// File: rtl/wkr_route.sv
module wkr_route #(
  parameter int N_CH  = 64,
  parameter int N_IRQ = 8,
  parameter int SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_CH-1:0]       pend_i,
  input  logic [N_CH-1:0]       ien_i,
  input  logic [N_CH-1:0]       wen_i,
  input  logic [N_CH*SEL_W-1:0] route_i,
  output logic [N_IRQ-1:0]      irq_o,
  output logic                  wake_o
);
  logic [N_IRQ-1:0] irq_n;
  logic [N_CH-1:0]  live;

  assign live = pend_i & ien_i;

  always_comb begin
    irq_n = '0;
    for (int k = 0; k < N_IRQ; k++)
      for (int c = 0; c < N_CH; c++)
        if (live[c] && route_i[c*SEL_W +: SEL_W] == SEL_W'(k)) irq_n[k] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= '0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= irq_n;
      wake_o <= |(pend_i & wen_i);
    end
  end
endmodule

// File: rtl/wkr_top.sv
module wkr_top
  import wkr_pkg::*;
#(
  parameter int N_CH        = 64,
  parameter int N_IRQ       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3 + $clog2(N_CH / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CH-1:0]   raw_i,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [N_IRQ-1:0]  irq_o,
  output logic              wake_o
);
  localparam int SEL_W = $clog2(N_IRQ);

  logic [N_CH-1:0]       hit_w;
  logic [N_CH-1:0]       ien_w;
  logic [N_CH-1:0]       wen_w;
  logic [N_CH-1:0]       pol_w;
  logic [N_CH-1:0]       pend_w;
  logic [N_CH*SEL_W-1:0] route_w;

  initial begin
    if (SEL_W > FIELD_W) $error("route selector wider than its field");
    if (N_CH % DATA_W != 0) $error("channel count must be a multiple of the word width");
  end

  wkr_sync_edge #(.N_CH(N_CH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw_i(raw_i), .pol_i(pol_w), .hit_o(hit_w)
  );

  wkr_regs #(.N_CH(N_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .hit_i(hit_w), .ien_o(ien_w), .wen_o(wen_w), .pol_o(pol_w), .pend_o(pend_w),
    .route_o(route_w), .rdata_o(reg_rdata)
  );

  wkr_route #(.N_CH(N_CH), .N_IRQ(N_IRQ), .SEL_W(SEL_W)) u_route (
    .clk(clk), .rst(rst), .pend_i(pend_w), .ien_i(ien_w), .wen_i(wen_w),
    .route_i(route_w), .irq_o(irq_o), .wake_o(wake_o)
  );
endmodule

// File: rtl/wkr_chk.sv
module wkr_chk #(
  parameter int N_CH   = 64,
  parameter int N_IRQ  = 8,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [N_IRQ-1:0]  irq,
  input logic              wake,
  input logic [N_CH-1:0]   pend,
  input logic [N_CH-1:0]   ien,
  input logic [N_CH-1:0]   wen,
  input logic [N_CH-1:0]   hit
);
  logic pend_wr;
  assign pend_wr = wr && (addr[ADDR_W-1:ADDR_W-3] == 3'd3);

  // R8
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (irq == '0 && !wake));

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(pend) & ~pend)) |-> $past(pend_wr));

  // R1
  pend_source_chk: assert property (@(posedge clk) disable iff (rst)
    (|(pend & ~$past(pend))) |-> $past(|hit));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(hit) & ~pend) == '0);

  // R7
  wake_source_chk: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(|(pend & wen)));

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    (|irq) |-> $past(|(pend & ien)));
endmodule

bind wkr_top wkr_chk #(.N_CH(N_CH), .N_IRQ(N_IRQ), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .irq(irq_o), .wake(wake_o),
  .pend(pend_w), .ien(ien_w), .wen(wen_w), .hit(hit_w)
);

// File: tb/sim_wkr_top.sv
module sim_wkr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] raw_i = '0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  irq_o;
  logic        wake_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wkr_top u0 (
    .clk(clk), .rst(rst), .raw_i(raw_i), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    tick(1);
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R8 irq after reset", irq_o, 0);
    check("R8 wake after reset", wake_o, 0);
    check("R8 rdata after reset", reg_rdata, 0);
    rd_reg(6'd24, d); check("R8 pending word0", d, 0);
    rd_reg(6'd0, d);  check("R8 ien word0", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr_reg(6'd1, 32'hA5A5_5A5A);
    rd_reg(6'd1, d); check("R9 ien word1 readback", d, 32'hA5A5_5A5A);
    wr_reg(6'd32, 32'h7654_3210);
    rd_reg(6'd32, d); check("R9 route word readback", d, 32'h7654_3210);
    wr_reg(6'd33, 32'hFFFF_FFFF);
    rd_reg(6'd33, d); check("R9 route spare bits read 0", d, 32'h7777_7777);
    rd_reg(6'd5, d); check("R9 unmapped reads 0", d, 0);
    check("R6 no irq without pending", irq_o, 0);
  endtask

  task automatic t_setup;
    wr_reg(6'd0, 32'h0000_0029);   // ien: ch0, ch3, ch5
    wr_reg(6'd1, 32'h8000_0000);   // ien: ch63
    wr_reg(6'd8, 32'h0000_0008);   // wen: ch3
    wr_reg(6'd17, 32'h0000_0100);  // pol: ch40 falling
    wr_reg(6'd32, 32'h0070_2000);  // ch3->2, ch5->7, ch0->0
    wr_reg(6'd33, 32'h0);
    wr_reg(6'd39, 32'h7000_0000);  // ch63->7
  endtask

  task automatic t_timing;
    raw_i[3] = 1'b1;
    tick(3);
    check("R1 wake not yet after 3 edges", wake_o, 0);
    check("R1 irq not yet after 3 edges", irq_o, 0);
    tick(1);
    check("R1 wake on edge 4", wake_o, 1);
    check("R5 ch3 on line 2", irq_o, 8'h04);
    wr_reg(6'd24, 32'h0000_0008);
    tick(1);
    check("R7 wake drops after clear", wake_o, 0);
    check("R3 irq drops after clear", irq_o, 0);
  endtask

  task automatic t_polarity;
    logic [31:0] d;
    raw_i[40] = 1'b1;
    tick(5);
    rd_reg(6'd25, d); check("R2 rising ignored on falling channel", d[8], 0);
    raw_i[40] = 1'b0;
    tick(5);
    rd_reg(6'd25, d); check("R2 falling sets pending", d[8], 1);
    check("R6 disabled channel drives no irq", irq_o, 0);
    check("R7 no wake without wake enable", wake_o, 0);
    wr_reg(6'd9, 32'h0000_0100);
    tick(1);
    check("R7 wake follows enable", wake_o, 1);
    wr_reg(6'd25, 32'h0000_0100);
    tick(1);
    check("R7 wake held until clear", wake_o, 0);
    wr_reg(6'd9, 32'h0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    raw_i[0] = 1'b1;
    tick(5);
    check("R5 ch0 on line 0", irq_o, 8'h01);
    wr_reg(6'd24, 32'h0);
    tick(1);
    rd_reg(6'd24, d); check("R3 write 0 keeps pending", d[0], 1);
    check("R3 irq kept", irq_o, 8'h01);
    wr_reg(6'd24, 32'h0000_0001);
    rd_reg(6'd24, d); check("R3 write 1 clears", d[0], 0);
  endtask

  task automatic t_setwins;
    logic [31:0] d;
    raw_i[0] = 1'b0;
    tick(5);
    raw_i[0] = 1'b1;
    tick(5);
    rd_reg(6'd24, d); check("R4 pending before collision", d[0], 1);
    raw_i[0] = 1'b0;
    tick(5);
    raw_i[0] = 1'b1;
    tick(2);
    wr_reg(6'd24, 32'h0000_0001);  // lands on the detection edge
    rd_reg(6'd24, d); check("R4 set wins over clear", d[0], 1);
    wr_reg(6'd24, 32'h0000_0001);
    tick(2);
  endtask

  task automatic t_shared;
    raw_i[5] = 1'b1; raw_i[63] = 1'b1; raw_i[3] = 1'b0;
    tick(5);
    check("R10 two channels on line 7", irq_o, 8'h80);
    raw_i[3] = 1'b1;
    tick(5);
    check("R5 lines 2 and 7 together", irq_o, 8'h84);
    wr_reg(6'd24, 32'h0000_0028);  // clear ch3, ch5
    tick(1);
    check("R10 line 7 held by ch63", irq_o, 8'h80);
    wr_reg(6'd25, 32'h8000_0000);
    tick(1);
    check("R10 line 7 drops after last clear", irq_o, 0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_regs();
    t_setup();
    t_timing();
    t_polarity();
    t_w1c();
    t_setwins();
    t_shared();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule